// File: doc/BRIEF.md
# Overcurrent Deglitch and Auto-Retry Supervisor

This block supervises four low-side output switches. An analog limiter beside each switch raises a flag while it is clamping that switch's current. The supervisor filters each flag with its own deglitch timer. Only a flag that stays up for longer than the deglitch window shuts its channel off. The channel then sits out a fixed retry interval and comes back on its own. A die-overheat flag forces every channel off for as long as it is raised. A supply-low flag forces every channel off and holds all channel state cleared until it drops.

A single active-low fault line reports the condition to the rest of the system. It goes low while any channel is serving a retry interval or the overheat flag is up. It stays high while the supply-low flag holds the logic cleared. The per-channel disable outputs feed the gate drive logic. All intervals are counted in system-clock cycles and set by parameters.

Top module: `ocp_supervisor`

## Requirements
- R1: While `rst_n` is sampled low, all channels return to the idle state at that edge. After it, with no overheat or supply-low flag, `chan_off_o` is 0 and `fault_n_o` is 1.
- R2: A channel's `chan_off_o` bit rises right after the (DEGLITCH_CYC+1)-th consecutive rising edge at which that channel's `ilim_i` bit is sampled high, and not earlier.
- R3: If `ilim_i` is sampled low before the deglitch window completes, the channel returns to idle. The next high run must then be a full fresh window of DEGLITCH_CYC+1 edges.
- R4: Once set by a deglitch, a channel's `chan_off_o` bit stays high for exactly RETRY_CYC samples and then clears by itself. `ilim_i` has no effect during that interval.
- R5: `fault_n_o` is 0 whenever any channel is in its retry interval, unless `uv_i` is high.
- R6: Channels are independent. Each bit of `chan_off_o` follows its own `ilim_i` bit and its own timers.
- R7: A single reset edge during a retry interval clears that channel at once, without waiting for the retry count.
- R8: While `uv_i` is high, every `chan_off_o` bit is 1, `fault_n_o` is 1, and every channel is forced to idle. When `uv_i` drops, the channels drive again at once, with no retry wait.
- R9: While `thermal_i` is high and `uv_i` is low, every `chan_off_o` bit is 1 and `fault_n_o` is 0. When `thermal_i` drops, each channel that is not in retry is enabled again in the same cycle.
- R10: When a retry interval ends while `ilim_i` is still high, the channel stays on for DEGLITCH_CYC+1 further samples. It is then disabled again after a full new deglitch window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all timing counts its rising edges |
| rst_n | input | 1 | Synchronous active-low reset; clears all channel state |
| uv_i | input | 1 | Supply-low flag; forces all channels off and clears their state |
| thermal_i | input | 1 | Overheat flag; forces all channels off and pulls the fault line low |
| ilim_i | input | NUM_CH | Per-channel current-limit-active flags from the analog limiters |
| chan_off_o | output | NUM_CH | Per-channel disable to the gate drive; 1 = switch off |
| fault_n_o | output | 1 | Active-low shared fault indication |

## Verification
The embedded assertions watch, on every cycle, the local state-machine rules. A broken deglitch run falls back to idle. A retry interval is never cut short except by a clear. Entry into retry always comes from a completed deglitch window. At the output merge, overheat and supply-low must force the expected levels. What only the bench scenarios can show are the exact cycle counts seen at the ports: the number of edges before a disable, the number of samples a disable lasts, and the fresh window needed after a retry while the flag stays high. The bench also covers the staggered timing of two channels running at once and the immediate release after a reset or a supply-low pulse.

// File: rtl/ocp_pkg.sv
// Package: shared types for the overcurrent supervisor.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package ocp_pkg;

    // Per-channel protection state.
    typedef enum logic [1:0] {
        CH_IDLE     = 2'd0,
        CH_DEGLITCH = 2'd1,
        CH_RETRY    = 2'd2
    } ch_state_e;

endpackage

// File: rtl/ocp_channel.sv
// Module: ocp_channel
// One channel's protection state machine. A current-limit flag must be seen
// high at DEGLITCH_CYC+1 consecutive edges before the channel enters the retry
// state. In retry it is held off for exactly RETRY_CYC cycles and then returns
// to idle on its own. A clear (reset or supply-low) forces idle at once.
// Assumes: ilim_i is already synchronous to clk; both cycle counts are >= 1.
module ocp_channel
    import ocp_pkg::*;
#(
    parameter int DEGLITCH_CYC = 350,
    parameter int RETRY_CYC    = 120000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic ilim_i,
    output logic retry_o
);

    localparam int MAX_CYC = (DEGLITCH_CYC > RETRY_CYC) ? DEGLITCH_CYC : RETRY_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] DG_LAST = CNT_W'(DEGLITCH_CYC - 1);
    localparam logic [CNT_W-1:0] RT_LAST = CNT_W'(RETRY_CYC - 1);

    ch_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // Next-state and counter selection for the deglitch / retry sequence.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            CH_IDLE: begin
                cnt_d = '0;
                if (ilim_i) state_d = CH_DEGLITCH;
            end
            CH_DEGLITCH: begin
                if (!ilim_i) begin
                    state_d = CH_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q == DG_LAST) begin
                    state_d = CH_RETRY;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            CH_RETRY: begin
                if (cnt_q == RT_LAST) begin
                    state_d = CH_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = CH_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // State register with synchronous reset and clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            state_q <= CH_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Retry state drives the channel's fault-off request.
    always_comb retry_o = (state_q == CH_RETRY);

    // A broken deglitch run falls back to idle.
    assert_deglitch_break_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_DEGLITCH && !ilim_i && !clr_i) |=> (state_q == CH_IDLE));

    // Retry is never cut short unless a clear arrives.
    assert_retry_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_RETRY && cnt_q != RT_LAST && !clr_i) |=> (state_q == CH_RETRY));

    // Entry into retry only follows a completed window with the flag still up.
    assert_enter_retry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(retry_o) |-> $past(state_q == CH_DEGLITCH && ilim_i && cnt_q == DG_LAST));

    // A clear always lands in idle.
    assert_clear_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (state_q == CH_IDLE));

endmodule

// File: rtl/ocp_fault_merge.sv
// Module: ocp_fault_merge
// Combines the per-channel retry requests with the global overheat and
// supply-low flags. It produces the per-channel disables and the shared
// active-low fault line. Supply-low keeps the fault line high.
// Assumes: flags are synchronous to clk; outputs are combinational.
module ocp_fault_merge #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] retry_i,
    input  logic              thermal_i,
    input  logic              uv_i,
    output logic [NUM_CH-1:0] chan_off_o,
    output logic              fault_n_o
);

    logic global_off;

    // Any global condition turns every switch off.
    always_comb global_off = thermal_i | uv_i;

    // Per-channel disable: own retry or a global shutdown.
    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_off
            always_comb chan_off_o[g] = retry_i[g] | global_off;
        end
    endgenerate

    // Fault line: low on retry or overheat, held high during supply-low.
    always_comb fault_n_o = uv_i | ~(thermal_i | (|retry_i));

    assert_thermal_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (thermal_i && !uv_i) |-> (!fault_n_o && (&chan_off_o)));

    assert_uv_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        uv_i |-> (fault_n_o && (&chan_off_o)));

    assert_fault_on_retry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((|retry_i) && !uv_i) |-> !fault_n_o);

endmodule

// File: rtl/ocp_supervisor.sv
// Module: ocp_supervisor (top)
// Overcurrent deglitch and auto-retry supervisor for NUM_CH low-side switches.
// It has one protection state machine per channel plus the shared fault merge.
// Assumes: all inputs are synchronous to clk; reset is synchronous, active low.
module ocp_supervisor #(
    parameter int NUM_CH       = 4,
    parameter int DEGLITCH_CYC = 350,
    parameter int RETRY_CYC    = 120000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uv_i,
    input  logic              thermal_i,
    input  logic [NUM_CH-1:0] ilim_i,
    output logic [NUM_CH-1:0] chan_off_o,
    output logic              fault_n_o
);

    logic [NUM_CH-1:0] retry;

    // One protection state machine per channel, cleared by supply-low.
    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_ch
            ocp_channel #(
                .DEGLITCH_CYC (DEGLITCH_CYC),
                .RETRY_CYC    (RETRY_CYC)
            ) u_ch (
                .clk     (clk),
                .rst_n   (rst_n),
                .clr_i   (uv_i),
                .ilim_i  (ilim_i[c]),
                .retry_o (retry[c])
            );
        end
    endgenerate

    ocp_fault_merge #(
        .NUM_CH (NUM_CH)
    ) u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .retry_i    (retry),
        .thermal_i  (thermal_i),
        .uv_i       (uv_i),
        .chan_off_o (chan_off_o),
        .fault_n_o  (fault_n_o)
    );

endmodule

// File: tb/ocp_supervisor_test.sv
module ocp_supervisor_test;

    localparam int NCH = 4;
    localparam int DG  = 4;
    localparam int RT  = 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           uv = 1'b0;
    logic           th = 1'b0;
    logic [NCH-1:0] ilim = '0;
    logic [NCH-1:0] off;
    logic           fault_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ocp_supervisor #(.NUM_CH(NCH), .DEGLITCH_CYC(DG), .RETRY_CYC(RT)) uut (
        .clk(clk), .rst_n(rst_n), .uv_i(uv), .thermal_i(th),
        .ilim_i(ilim), .chan_off_o(off), .fault_n_o(fault_n)
    );

    // Vector: {req[3:0], rst_n, uv, th, ilim[3:0], exp_off[3:0], exp_fault_n}
    localparam int NV = 18;
    localparam logic [15:0] VEC [NV] = '{
        {4'd1,  1'b0,1'b0,1'b0, 4'b0000, 4'b0000, 1'b1}, // R1 reset
        {4'd2,  1'b1,1'b0,1'b0, 4'b0001, 4'b0000, 1'b1}, // R2 edge 1
        {4'd2,  1'b1,1'b0,1'b0, 4'b0001, 4'b0000, 1'b1},
        {4'd2,  1'b1,1'b0,1'b0, 4'b0001, 4'b0000, 1'b1},
        {4'd2,  1'b1,1'b0,1'b0, 4'b0001, 4'b0000, 1'b1}, // edge 4
        {4'd3,  1'b1,1'b0,1'b0, 4'b0000, 4'b0000, 1'b1}, // R3 run broken
        {4'd3,  1'b1,1'b0,1'b0, 4'b0001, 4'b0000, 1'b1}, // R3 fresh window
        {4'd3,  1'b1,1'b0,1'b0, 4'b0001, 4'b0000, 1'b1},
        {4'd3,  1'b1,1'b0,1'b0, 4'b0001, 4'b0000, 1'b1},
        {4'd3,  1'b1,1'b0,1'b0, 4'b0001, 4'b0000, 1'b1},
        {4'd5,  1'b1,1'b0,1'b0, 4'b0001, 4'b0001, 1'b0}, // R2/R5 fifth edge
        {4'd6,  1'b1,1'b0,1'b0, 4'b0011, 4'b0001, 1'b0}, // R6 ch1 only counting
        {4'd9,  1'b1,1'b0,1'b1, 4'b0011, 4'b1111, 1'b0}, // R9 overheat
        {4'd9,  1'b1,1'b0,1'b0, 4'b0000, 4'b0001, 1'b0}, // R9 release
        {4'd8,  1'b1,1'b1,1'b0, 4'b0000, 4'b1111, 1'b1}, // R8 supply low
        {4'd8,  1'b1,1'b0,1'b0, 4'b0000, 4'b0000, 1'b1}, // R8 retry cleared
        {4'd8,  1'b1,1'b1,1'b1, 4'b0000, 4'b1111, 1'b1}, // R8 over R9
        {4'd8,  1'b1,1'b0,1'b0, 4'b0000, 4'b0000, 1'b1}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [NCH:0] got, input logic [NCH:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s off/fault_n got=%b expected=%b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic run_edges(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    initial begin : main
        int hi;
        // Table walk: drive, one edge, compare.
        for (int i = 0; i < NV; i++) begin
            rst_n = VEC[i][11];
            uv    = VEC[i][10];
            th    = VEC[i][9];
            ilim  = VEC[i][8:5];
            tick();
            check($sformatf("R%0d vec%0d", VEC[i][15:12], i), {off, fault_n}, VEC[i][4:0]);
        end

        // R4 / R10: retry length, flag ignored, fresh window afterwards.
        ilim = 4'b0100;
        run_edges(DG);
        check("R2 ch2 not yet", {off, fault_n}, 5'b00001);
        tick();
        hi = 0;
        while (off[2] && hi < 3 * RT) begin
            hi++;
            tick();
        end
        check("R4 retry samples", {28'd0, hi[4:0]}, {28'd0, 5'(RT)});
        check("R10 after retry", {off, fault_n}, 5'b00001);
        run_edges(DG);
        check("R10 still on", {off, fault_n}, 5'b00001);
        tick();
        check("R10 disabled again", {off, fault_n}, 5'b01000);

        // R7: one reset edge during retry clears immediately.
        ilim = '0;
        rst_n = 1'b0;
        tick();
        check("R7 reset clears", {off, fault_n}, 5'b00001);
        rst_n = 1'b1;
        tick();
        check("R1 idle after reset", {off, fault_n}, 5'b00001);

        // R6: two channels staggered by two edges.
        ilim = 4'b0001;
        run_edges(2);
        ilim = 4'b1001;
        run_edges(3);
        check("R6 ch0 first", {off, fault_n}, 5'b00010);
        run_edges(2);
        check("R6 both off", {off, fault_n}, 5'b10010);
        ilim = '0;
        run_edges(RT - 2);
        check("R6 ch0 released", {off, fault_n}, 5'b10000);
        run_edges(2);
        check("R6 ch3 released", {off, fault_n}, 5'b00001);

        // R9: overheat held across edges, release same cycle.
        th = 1'b1;
        tick();
        check("R9 overheat", {off, fault_n}, 5'b11110);
        th = 1'b0;
        #1;
        check("R9 immediate release", {off, fault_n}, 5'b00001);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : watchdog
        #(200000 * 10);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired got=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule